// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block holds a bank of free-running 32-bit counters for one cache slice. Every counter picks one of 256 event lines through its own 8-bit selector and adds one for each cycle in which that line is high. Counting requires the global run bit and the counter's own enable. Software reads the counters and never has to reload them. Each counter can flag a status bit whenever its most significant bit changes. It flags when bit 31 rises and again when the count wraps to zero. Software can therefore take deltas from free-running counts, provided it reads at least once per half range.

An even-numbered counter can be joined to the counter above it to form one 64-bit count. The odd counter of the pair then ignores its own selector and advances only on the carry out of its even partner. A flat register file sets up the bank: a run bit, enable set and enable clear words, a chain word, an interrupt-enable word, a write-one-to-clear status word, per-counter selectors and directly loadable counts. The single interrupt line is high while any status bit whose enable is set is high.

Top module: `evt_counter_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every counter, selector, enable, chain bit, interrupt enable and status bit reads 0, and irq is low.
- R2: With run bit 0 of CTRL (address 0x00) set, counter i adds exactly 1 in each cycle where its enable bit is 1 and evt_in[selector i] is 1. It wraps modulo 2^32. Writes take effect from the cycle after the write edge.
- R3: A write to ENSET (0x01) sets the enable bits where the data has ones, and zero bits leave enables alone. A write to ENCLR (0x02) clears the enable bits where the data has ones. Both addresses read back the enable mask.
- R4: While CTRL bit 0 is 0, no counter changes except through a software load, whatever the enables are.
- R5: The selector of counter i is an 8-bit value at address 0x08+i. It reads back, and it picks the event input index.
- R6: When an increment changes bit 31 of counter i (0 to 1, or the wrap from all ones to zero) and bit i of IRQEN (0x04) is 1, bit i of STATUS (0x05) becomes 1. With IRQEN bit i at 0 the status bit is not set.
- R7: STATUS is write-one-to-clear. If a clear and a new set of the same bit fall in one cycle, the bit stays 1.
- R8: irq is 1 exactly when some bit is 1 in both STATUS and IRQEN.
- R9: Bit 2k of CHAIN (0x03) makes counter 2k+1 the upper half of a 64-bit count. When its own enable is set, it adds 1 only in a cycle where counter 2k increments from all ones, and its own selector has no effect.
- R10: Only the even bits of CHAIN are stored (mask 0x55). Odd bits are dropped on write and read back as 0, and an odd counter never acts as the lower half of a pair.
- R11: A write to address 0x10+i loads counter i. In that cycle the load replaces any increment, gives no carry to the upper partner and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 256 | Event pulse lines, one per selector code |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 6 | Register write word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 6 | Register read word address |
| reg_rd_data | output | 32 | Read data for reg_rd_addr, combinational |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
Assertions watch every cycle for the properties that stay local to one counter or to the status word. A stopped counter holds its value. An enabled hit adds exactly one. A load wins over an increment. An upper counter stays still unless its partner carries. A set wins over a clear. The interrupt never rises without a status bit behind it. Only the bench's scenarios can show that the register decode maps each address to the right field. They also show the exact cycle when bit 31 rises or wraps under preloaded values, the 64-bit carry across a pair, and that dropped odd chain bits do not disturb the bank. A behavioural model compared on every clock covers the long random mix of writes and events.

// File: rtl/evcb_pkg.sv
// Package: register map of the chainable event counter bank.
// Assumes a 6-bit word address space and at most 8 counters, so the
// selector and count windows (8 words each) do not overlap.
package evcb_pkg;
    localparam int ADDR_W = 6;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t A_CTRL     = 6'h00;
    localparam reg_addr_t A_EN_SET   = 6'h01;
    localparam reg_addr_t A_EN_CLR   = 6'h02;
    localparam reg_addr_t A_CHAIN    = 6'h03;
    localparam reg_addr_t A_IRQ_EN   = 6'h04;
    localparam reg_addr_t A_STATUS   = 6'h05;
    localparam reg_addr_t A_SEL_BASE = 6'h08;
    localparam reg_addr_t A_CNT_BASE = 6'h10;
endpackage

// File: rtl/evcb_counter.sv
// Module: one free-running event counter.
// Counts a selected event line, or the carry of its lower partner when
// it serves as the upper half of a chained pair. A software load has
// priority over counting and suppresses carry and top-bit toggle output.
// Assumes W >= 2.
module evcb_counter #(
    parameter int W     = 32,
    parameter int SEL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<SEL_W)-1:0] evt_in,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  run,
    input  logic                  upper_mode,
    input  logic                  carry_in,
    input  logic                  load,
    input  logic [W-1:0]          load_val,
    output logic [W-1:0]          count,
    output logic                  carry_out,
    output logic                  msb_toggle
);
    logic [W-1:0] count_q;
    logic         hit;
    logic         inc;
    logic         inc_eff;

    // Pick the event source: partner carry when chained, else selected line.
    always_comb begin
        hit     = evt_in[sel];
        inc     = run & (upper_mode ? carry_in : hit);
        inc_eff = inc & ~load;
    end

    // Carry leaves when the counter steps from all ones; bit W-1 flips
    // whenever the lower W-1 bits are all ones.
    assign carry_out  = inc_eff & (&count_q);
    assign msb_toggle = inc_eff & (&count_q[W-2:0]);
    assign count      = count_q;

    // Count state: reset, load, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (load)    count_q <= load_val;
        else if (inc)     count_q <= count_q + W'(1);
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count_q));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !upper_mode && evt_in[sel] && !load) |=> (count_q == $past(count_q) + W'(1)));
    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val)));
endmodule

// File: rtl/evcb_status.sv
// Module: overflow status word and interrupt line.
// A bit is set by a top-bit toggle of its counter while its interrupt
// enable is on; software clears by writing ones. Set beats clear.
module evcb_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] toggle,
    input  logic [N-1:0] irq_en,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] status_q;
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;

    // Requests for this cycle.
    always_comb begin
        set_vec = toggle & irq_en;
        clr_vec = clr_we ? clr_mask : '0;
    end

    // Status register: clear first, then OR in new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | set_vec;
    end

    assign status = status_q;
    assign irq    = |(status_q & irq_en);

    for (genvar b = 0; b < N; b++) begin : g_chk
        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (toggle[b] && irq_en[b]) |=> status_q[b]);
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[b] && !(toggle[b] && irq_en[b])) |=> !status_q[b]);
        p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_en[b] && !status_q[b]) |=> !status_q[b]);
    end
    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q != '0));
endmodule

// File: rtl/evt_counter_bank.sv
// Module: top of the chainable event counter bank.
// Holds the configuration registers, decodes register writes, builds
// the read mux and instantiates one counter per slot plus the status
// unit. Assumes NUM_CTRS is even and at most 8, CNT_W is 32 (the
// register data width) and SEL_W is at most CNT_W.
module evt_counter_bank
    import evcb_pkg::*;
#(
    parameter int NUM_CTRS = 8,
    parameter int CNT_W    = 32,
    parameter int SEL_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<SEL_W)-1:0] evt_in,
    input  logic                  reg_wr_en,
    input  logic [ADDR_W-1:0]     reg_wr_addr,
    input  logic [CNT_W-1:0]      reg_wr_data,
    input  logic [ADDR_W-1:0]     reg_rd_addr,
    output logic [CNT_W-1:0]      reg_rd_data,
    output logic                  irq
);
    localparam int N = NUM_CTRS;

    // Even positions only may carry a chain bit.
    function automatic logic [N-1:0] f_even_mask();
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = (i % 2 == 0);
        return m;
    endfunction
    localparam logic [N-1:0] CHAIN_MASK = f_even_mask();

    logic               run_q;
    logic [N-1:0]       en_q;
    logic [N-1:0]       chain_q;
    logic [N-1:0]       ien_q;
    logic [SEL_W-1:0]   sel_q [N];
    logic [CNT_W-1:0]   cnt   [N];
    logic [N-1:0]       carry;
    logic [N-1:0]       toggle;
    logic [N-1:0]       status;

    logic               wr_ctrl, wr_set, wr_clr, wr_chain, wr_ien, wr_stat;
    logic [N-1:0]       wr_sel, wr_cnt;

    // Write address decode.
    always_comb begin
        wr_ctrl  = reg_wr_en && (reg_wr_addr == A_CTRL);
        wr_set   = reg_wr_en && (reg_wr_addr == A_EN_SET);
        wr_clr   = reg_wr_en && (reg_wr_addr == A_EN_CLR);
        wr_chain = reg_wr_en && (reg_wr_addr == A_CHAIN);
        wr_ien   = reg_wr_en && (reg_wr_addr == A_IRQ_EN);
        wr_stat  = reg_wr_en && (reg_wr_addr == A_STATUS);
        for (int i = 0; i < N; i++) begin
            wr_sel[i] = reg_wr_en && (reg_wr_addr == A_SEL_BASE + ADDR_W'(i));
            wr_cnt[i] = reg_wr_en && (reg_wr_addr == A_CNT_BASE + ADDR_W'(i));
        end
    end

    // Control, enable, chain and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            en_q    <= '0;
            chain_q <= '0;
            ien_q   <= '0;
        end else begin
            if (wr_ctrl)  run_q   <= reg_wr_data[0];
            if (wr_set)   en_q    <= en_q | reg_wr_data[N-1:0];
            if (wr_clr)   en_q    <= en_q & ~reg_wr_data[N-1:0];
            if (wr_chain) chain_q <= reg_wr_data[N-1:0] & CHAIN_MASK;
            if (wr_ien)   ien_q   <= reg_wr_data[N-1:0];
        end
    end

    // Per-counter event selectors.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n)         sel_q[i] <= '0;
            else if (wr_sel[i]) sel_q[i] <= reg_wr_data[SEL_W-1:0];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_ctr
        logic up_mode;
        logic cin;
        if (g % 2 == 1) begin : g_odd
            assign up_mode = chain_q[g-1];
            assign cin     = carry[g-1];
        end else begin : g_even
            assign up_mode = 1'b0;
            assign cin     = 1'b0;
        end
        evcb_counter #(.W(CNT_W), .SEL_W(SEL_W)) i_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_in     (evt_in),
            .sel        (sel_q[g]),
            .run        (run_q & en_q[g]),
            .upper_mode (up_mode),
            .carry_in   (cin),
            .load       (wr_cnt[g]),
            .load_val   (reg_wr_data),
            .count      (cnt[g]),
            .carry_out  (carry[g]),
            .msb_toggle (toggle[g])
        );
    end

    evcb_status #(.N(N)) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle   (toggle),
        .irq_en   (ien_q),
        .clr_we   (wr_stat),
        .clr_mask (reg_wr_data[N-1:0]),
        .status   (status),
        .irq      (irq)
    );

    // Read mux over the register map.
    always_comb begin
        reg_rd_data = '0;
        case (reg_rd_addr)
            A_CTRL:             reg_rd_data = CNT_W'(run_q);
            A_EN_SET, A_EN_CLR: reg_rd_data = CNT_W'(en_q);
            A_CHAIN:            reg_rd_data = CNT_W'(chain_q);
            A_IRQ_EN:           reg_rd_data = CNT_W'(ien_q);
            A_STATUS:           reg_rd_data = CNT_W'(status);
            default: begin
                for (int i = 0; i < N; i++) begin
                    if (reg_rd_addr == A_SEL_BASE + ADDR_W'(i)) reg_rd_data = CNT_W'(sel_q[i]);
                    if (reg_rd_addr == A_CNT_BASE + ADDR_W'(i)) reg_rd_data = cnt[i];
                end
            end
        endcase
    end

    for (genvar p = 0; p < N / 2; p++) begin : g_pair_chk
        p_upper_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (chain_q[2*p] && !wr_cnt[2*p+1] && (cnt[2*p] != '1)) |=> $stable(cnt[2*p+1]));
    end
    p_odd_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_chain |=> ((chain_q & ~CHAIN_MASK) == '0));
endmodule

// File: tb/test_evt_counter_bank.sv
// Bench: drives register writes and event lines, keeps a behavioural
// model of the bank updated at every rising edge, and compares irq and
// the read port against it at every falling edge. Directed checks use
// hand-derived values tagged with their requirement.
module test_evt_counter_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] evt = '0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [5:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         irq;

    int n_vec = 0;
    int n_fail = 0;
    int rot = 0;

    // Model state.
    bit        m_run;
    bit [7:0]  m_en, m_chain, m_ien, m_stat;
    bit [7:0]  m_sel [NC];
    bit [31:0] m_cnt [NC];

    evt_counter_bank i_evt_counter_bank (
        .clk(clk), .rst_n(rst_n), .evt_in(evt),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .reg_rd_addr(rd_addr), .reg_rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [5:0] addr_of(int k);
        if (k < 6)  return 6'(k);
        if (k < 14) return 6'(8 + k - 6);
        return 6'(16 + k - 14);
    endfunction

    function automatic bit [31:0] model_read(bit [5:0] a);
        if (a == 0) return 32'(m_run);
        if (a == 1 || a == 2) return 32'(m_en);
        if (a == 3) return 32'(m_chain);
        if (a == 4) return 32'(m_ien);
        if (a == 5) return 32'(m_stat);
        if (a >= 8 && a < 16) return 32'(m_sel[a-8]);
        if (a >= 16 && a < 24) return m_cnt[a-16];
        return 32'h0;
    endfunction

    task automatic model_update();
        bit inc [NC];
        bit cry [NC];
        bit [7:0] tog;
        bit [7:0] clr;
        if (!rst_n) begin
            m_run = 0; m_en = 0; m_chain = 0; m_ien = 0; m_stat = 0;
            for (int i = 0; i < NC; i++) begin m_sel[i] = 0; m_cnt[i] = 0; end
            return;
        end
        tog = 0;
        for (int i = 0; i < NC; i++) begin
            bit ld = wr_en && (wr_addr == 6'(16 + i));
            bit act = m_run && m_en[i];
            if (i % 2 == 1 && m_chain[i-1]) inc[i] = act && cry[i-1];
            else                            inc[i] = act && evt[m_sel[i]];
            if (ld) inc[i] = 0;
            cry[i] = inc[i] && (m_cnt[i] == 32'hFFFF_FFFF);
            if (inc[i]) begin
                bit [31:0] nx = m_cnt[i] + 1;
                tog[i] = (nx[31] != m_cnt[i][31]);
            end
        end
        clr = (wr_en && wr_addr == 5) ? wr_data[7:0] : 8'h0;
        m_stat = (m_stat & ~clr) | (tog & m_ien);
        for (int i = 0; i < NC; i++) begin
            if (wr_en && wr_addr == 6'(16 + i)) m_cnt[i] = wr_data;
            else if (inc[i])                     m_cnt[i] = m_cnt[i] + 1;
            if (wr_en && wr_addr == 6'(8 + i))  m_sel[i] = wr_data[7:0];
        end
        if (wr_en) begin
            case (wr_addr)
                0: m_run = wr_data[0];
                1: m_en = m_en | wr_data[7:0];
                2: m_en = m_en & ~wr_data[7:0];
                3: m_chain = wr_data[7:0] & 8'h55;
                4: m_ien = wr_data[7:0];
                default: ;
            endcase
        end
    endtask

    // One clock: model follows the edge, outputs compared mid-cycle.
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        n_vec++;
        if (irq !== |(m_stat & m_ien) || rd_data !== model_read(rd_addr)) begin
            n_fail++;
            $display("FAIL model compare addr %0d: rd %h irq %b, expected rd %h irq %b",
                     rd_addr, rd_data, irq, model_read(rd_addr), |(m_stat & m_ien));
        end
        rot = (rot + 1) % 22;
        rd_addr = addr_of(rot);
    endtask

    task automatic wr(input bit [5:0] a, input bit [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic check_reg(input bit [5:0] a, input bit [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        n_vec++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: addr %0d read %h, expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic check_irq(input bit exp, input string tag);
        n_vec++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq %b, expected %b", tag, irq, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        // R1 reset state
        check_reg(0, 0, "R1 ctrl");
        check_reg(1, 0, "R1 enables");
        check_reg(16, 0, "R1 count0");
        check_reg(5, 0, "R1 status");
        check_irq(0, "R1 irq");

        // R5 selector readback
        wr(8, 32'h21);
        check_reg(8, 32'h21, "R5 sel0");

        // R3 enable set/clear semantics
        wr(1, 32'h01); check_reg(1, 32'h01, "R3 set");
        wr(1, 32'h00); check_reg(1, 32'h01, "R3 set zero ignored");
        wr(1, 32'h06); check_reg(2, 32'h07, "R3 set more");
        wr(2, 32'h02); check_reg(1, 32'h05, "R3 clear");
        wr(2, 32'h00); check_reg(2, 32'h05, "R3 clear zero ignored");
        wr(2, 32'h04); check_reg(1, 32'h01, "R3 clear again");

        // R2 counting of selected event 0x21
        wr(0, 1);
        evt[8'h21] = 1; evt[8'h22] = 1;
        repeat (10) step();
        evt = '0;
        check_reg(16, 10, "R2 ten hits");

        // R4 global stop
        wr(0, 0);
        evt[8'h21] = 1;
        repeat (5) step();
        evt = '0;
        check_reg(16, 10, "R4 stopped");

        // R6 rise of bit 31
        wr(10, 3); wr(4, 4); wr(1, 4); wr(0, 1);
        wr(18, 32'h7FFF_FFFE);
        evt[3] = 1;
        step();
        check_reg(18, 32'h7FFF_FFFF, "R6 before rise");
        check_irq(0, "R6 no irq yet");
        step();
        evt[3] = 0;
        check_reg(18, 32'h8000_0000, "R6 rise count");
        check_reg(5, 32'h4, "R6 rise status");
        check_irq(1, "R8 irq on");
        wr(5, 4);
        check_reg(5, 0, "R7 w1c");
        check_irq(0, "R8 irq off");

        // R6 wrap
        wr(18, 32'hFFFF_FFFF);
        evt[3] = 1; step(); evt[3] = 0;
        check_reg(18, 0, "R6 wrap count");
        check_reg(5, 32'h4, "R6 wrap status");
        wr(5, 4);

        // R7 clear and set in the same cycle
        wr(18, 32'h7FFF_FFFF);
        evt[3] = 1; step(); evt[3] = 0;
        wr(18, 32'hFFFF_FFFF);
        check_reg(5, 32'h4, "R7 pre");
        evt[3] = 1; wr(5, 4); evt[3] = 0;
        check_reg(5, 32'h4, "R7 set beats clear");
        check_reg(18, 0, "R7 count wrapped");
        wr(5, 4);

        // R6 no set with interrupt enable off
        wr(4, 0);
        wr(18, 32'h7FFF_FFFF);
        evt[3] = 1; step(); evt[3] = 0;
        check_reg(5, 0, "R6 masked");
        check_irq(0, "R6 masked irq");

        // R8 irq follows enable
        wr(4, 4);
        wr(18, 32'h7FFF_FFFF);
        evt[3] = 1; step(); evt[3] = 0;
        check_irq(1, "R8 irq set");
        wr(4, 0);
        check_irq(0, "R8 irq masked");
        check_reg(5, 32'h4, "R8 status kept");
        wr(5, 4);

        // R9 chained pair 4/5
        wr(12, 9); wr(13, 10); wr(1, 32'h30); wr(3, 32'h10);
        check_reg(3, 32'h10, "R9 chain readback");
        wr(20, 32'hFFFF_FFFE); wr(21, 5);
        evt[9] = 1; evt[10] = 1;
        step();
        check_reg(21, 5, "R9 upper ignores own event");
        step(); step();
        evt = '0;
        check_reg(20, 1, "R9 lower");
        check_reg(21, 6, "R9 upper carry");

        // R10 odd chain bits dropped
        wr(3, 32'h02);
        check_reg(3, 0, "R10 odd bit read");
        wr(9, 11); wr(1, 2); wr(17, 0);
        evt[11] = 1; step(); step(); evt = '0;
        check_reg(17, 2, "R10 counter1 independent");
        wr(3, 32'hAA);
        check_reg(3, 0, "R10 odd mask");

        // R11 load beats increment
        evt[8'h21] = 1;
        wr(16, 100);
        check_reg(16, 100, "R11 load wins");
        step();
        evt = '0;
        check_reg(16, 101, "R11 counts after load");

        // Random mix checked against the model every clock.
        for (int c = 0; c < 3000; c++) begin
            evt = {8{$urandom}};
            if ($urandom_range(0, 3) == 0) begin
                int k = $urandom_range(0, 21);
                bit [31:0] d = $urandom;
                if (k == 0) d = {31'b0, ($urandom_range(0, 3) != 0)};
                if (k >= 14 && $urandom_range(0, 1) == 1)
                    d = ($urandom_range(0, 1) ? 32'h7FFF_FFF0 : 32'hFFFF_FFF0) | 32'($urandom_range(0, 15));
                wr_en = 1; wr_addr = addr_of(k); wr_data = d;
            end else begin
                wr_en = 0;
            end
            step();
        end
        wr_en = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule